// File: doc/BRIEF.md
# Graded-Width Bar Test Pattern Generator

This block paints a fixed test image for a 16-bit RGB video DAC. An external sync generator supplies the pixel clock and four timing inputs: a one-cycle pulse at the first visible pixel of a line, a one-cycle pulse once per frame during vertical blanking, and horizontal and vertical blanking levels. The block opens its own display window from these inputs. It keeps x and y pixel counters inside that window and selects each pixel's colour from the counter values.

The image has a solid blue frame of parameterised thickness. Inside the frame are alternating black and white vertical bars. The pattern area is split vertically into seven equal bands. The top band has bars 64 pixels wide, and each band below halves the width, so the bottom band alternates on every pixel. A single frame therefore tests the DAC and the display from coarse bars down to full pixel-rate toggling. Outside the window the colour is forced to zero and the active-low blank output is asserted, so no retrace artefacts can appear.

The screen size and frame thickness are parameters. A reduced screen keeps simulation short.

Top module: `bar_pattern_gen`

## Requirements
- R1: The colour output is 5-6-5 RGB (red 5 bits, green 6, blue 5). White is all ones (0xFFFF as {red,green,blue}), black is 0x0000, and the frame colour is blue only, 0x001F. No other colour is ever shown.
- R2: While reset is high, and on the first cycle after it, the colour outputs are zero and blank_n is low.
- R3: The window opens on the clock edge that samples line_start while both blanking inputs are low. It closes on the edge that samples either blanking input high. blank_n and the colour reach the outputs two clock edges after the input cycle they belong to. Whenever blank_n is low, the colour is zero.
- R4: x is 0 in the pixel whose input cycle carries line_start, and it increases by one in each following input cycle that has both blanking inputs low.
- R5: A visible pixel is frame-blue when x < BORDER, x >= WIDTH-BORDER, y < BORDER or y >= HEIGHT-BORDER.
- R6: Any other visible pixel lies in band k = (y-BORDER)/BAND_H, limited to 6, where BAND_H = (HEIGHT-2*BORDER)/7. It is white when bit (6-k) of (x-BORDER) is 1 and black otherwise. Band 0 therefore has bars 64 wide and band 6 alternates every pixel, starting with black.
- R7: frame_start sets y to 0. y increases by one at the end of each visible line, and only visible lines are counted.
- R8: A line_start pulse while vblank is high is ignored: no window opens and blank_n stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse at the first visible pixel of a line |
| frame_start | input | 1 | One-cycle pulse during vertical blanking, before the first line |
| hblank | input | 1 | Horizontal blanking level, active high |
| vblank | input | 1 | Vertical blanking level, active high |
| red | output | 5 | Registered red channel |
| green | output | 6 | Registered green channel |
| blue | output | 5 | Registered blue channel |
| blank_n | output | 1 | Registered active-low blank to the DAC |

## Verification
The assertions assume well-formed timing from the sync generator: line_start comes only in the first cycle of a stretch in which hblank is low, frame_start comes while vblank is high, and no line has more than WIDTH visible cycles. The stimulus builds every line from these rules: a line_start pulse, WIDTH cycles with hblank low, then a blanking run. The only exception is a deliberate line_start inside vertical blanking, which checks that the pulse is ignored. The bench runs on a reduced screen and covers two frames, so the y counter and the band position must reset correctly at the second frame_start.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  typedef struct packed {
    logic [4:0] r;
    logic [5:0] g;
    logic [4:0] b;
  } rgb565_t;

  localparam rgb565_t COL_WHITE = '{r: 5'h1f, g: 6'h3f, b: 5'h1f};
  localparam rgb565_t COL_BLACK = '{r: 5'h00, g: 6'h00, b: 5'h00};
  localparam rgb565_t COL_BLUE  = '{r: 5'h00, g: 6'h00, b: 5'h1f};

  localparam int NUM_BANDS = 7;
  localparam int BAND_IDX_W = 3;
endpackage

// File: rtl/bpg_line_window.sv
module bpg_line_window #(
  parameter int XW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic          hblank,
  input  logic          vblank,
  output logic          win,
  output logic [XW-1:0] x,
  output logic          line_end
);
  logic blanking;
  assign blanking = hblank | vblank;

  // A window is open and blanking arrives: this is the last visible pixel.
  assign line_end = win & blanking;

  always_ff @(posedge clk) begin
    if (rst) begin
      win <= 1'b0;
      x   <= '0;
    end else begin
      if (blanking)        win <= 1'b0;
      else if (line_start) win <= 1'b1;

      if (line_start)         x <= '0;
      else if (win && !blanking) x <= x + 1'b1;
    end
  end
endmodule

// File: rtl/bpg_row_tracker.sv
module bpg_row_tracker #(
  parameter int HEIGHT = 480,
  parameter int BORDER = 16,
  parameter int YW     = 9
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           frame_start,
  input  logic                           line_end,
  output logic [YW-1:0]                  y,
  output logic [bpg_pkg::BAND_IDX_W-1:0] band
);
  import bpg_pkg::*;

  localparam int BAND_H = (HEIGHT - 2 * BORDER) / NUM_BANDS;
  localparam int RW     = (BAND_H > 1) ? $clog2(BAND_H) : 1;
  localparam logic [YW-1:0] Y_TOP = YW'(BORDER);
  localparam logic [YW-1:0] Y_BOT = YW'(HEIGHT - BORDER);
  localparam logic [YW-1:0] Y_MAX = YW'(HEIGHT);
  localparam logic [RW-1:0] ROW_LAST = RW'(BAND_H - 1);
  localparam logic [BAND_IDX_W-1:0] BAND_LAST = BAND_IDX_W'(NUM_BANDS - 1);

  logic [RW-1:0] row;
  logic          in_pattern;

  assign in_pattern = (y >= Y_TOP) && (y < Y_BOT);

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      y    <= '0;
      row  <= '0;
      band <= '0;
    end else if (line_end) begin
      if (y != Y_MAX) y <= y + 1'b1;
      if (in_pattern) begin
        if (row == ROW_LAST) begin
          row <= '0;
          if (band != BAND_LAST) band <= band + 1'b1;
        end else begin
          row <= row + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bpg_colour_sel.sv
module bpg_colour_sel #(
  parameter int WIDTH  = 640,
  parameter int HEIGHT = 480,
  parameter int BORDER = 16,
  parameter int XW     = 10,
  parameter int YW     = 9
) (
  input  logic [XW-1:0]                  x,
  input  logic [YW-1:0]                  y,
  input  logic [bpg_pkg::BAND_IDX_W-1:0] band,
  output bpg_pkg::rgb565_t               colour
);
  import bpg_pkg::*;

  localparam logic [XW-1:0] X_LO = XW'(BORDER);
  localparam logic [XW-1:0] X_HI = XW'(WIDTH - BORDER);
  localparam logic [YW-1:0] Y_LO = YW'(BORDER);
  localparam logic [YW-1:0] Y_HI = YW'(HEIGHT - BORDER);
  localparam logic [BAND_IDX_W-1:0] TOP_BIT = BAND_IDX_W'(NUM_BANDS - 1);

  logic                  in_frame;
  logic [XW-1:0]         px;
  logic [XW-1:0]         px_shift;
  logic [BAND_IDX_W-1:0] shamt;

  always_comb begin
    in_frame = (x < X_LO) || (x >= X_HI) || (y < Y_LO) || (y >= Y_HI);
    px       = x - X_LO;
    shamt    = TOP_BIT - band;
    px_shift = px >> shamt;
    if (in_frame)         colour = COL_BLUE;
    else if (px_shift[0]) colour = COL_WHITE;
    else                  colour = COL_BLACK;
  end
endmodule

// File: rtl/bar_pattern_gen.sv
module bar_pattern_gen #(
  parameter int WIDTH  = 640,
  parameter int HEIGHT = 480,
  parameter int BORDER = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_start,
  input  logic       frame_start,
  input  logic       hblank,
  input  logic       vblank,
  output logic [4:0] red,
  output logic [5:0] green,
  output logic [4:0] blue,
  output logic       blank_n
);
  import bpg_pkg::*;

  localparam int XW = $clog2(WIDTH + 1);
  localparam int YW = $clog2(HEIGHT + 1);

  logic                  win;
  logic                  line_end;
  logic [XW-1:0]         x;
  logic [YW-1:0]         y;
  logic [BAND_IDX_W-1:0] band;
  rgb565_t               colour;
  rgb565_t               colour_q;
  logic                  blank_n_q;

  bpg_line_window #(.XW(XW)) i_window (
    .clk(clk), .rst(rst), .line_start(line_start),
    .hblank(hblank), .vblank(vblank),
    .win(win), .x(x), .line_end(line_end)
  );

  bpg_row_tracker #(.HEIGHT(HEIGHT), .BORDER(BORDER), .YW(YW)) i_rows (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .line_end(line_end), .y(y), .band(band)
  );

  bpg_colour_sel #(
    .WIDTH(WIDTH), .HEIGHT(HEIGHT), .BORDER(BORDER), .XW(XW), .YW(YW)
  ) i_colour (
    .x(x), .y(y), .band(band), .colour(colour)
  );

  // One output register; window and colour share it, so they stay aligned.
  always_ff @(posedge clk) begin
    if (rst) begin
      colour_q  <= COL_BLACK;
      blank_n_q <= 1'b0;
    end else begin
      colour_q  <= win ? colour : COL_BLACK;
      blank_n_q <= win;
    end
  end

  assign red     = colour_q.r;
  assign green   = colour_q.g;
  assign blue    = colour_q.b;
  assign blank_n = blank_n_q;
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker #(
  parameter int BORDER = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       line_start,
  input logic       hblank,
  input logic       vblank,
  input logic [4:0] red,
  input logic [5:0] green,
  input logic [4:0] blue,
  input logic       blank_n
);
  logic [15:0] rgb;
  assign rgb = {red, green, blue};

  // R3
  blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !blank_n |-> rgb == 16'h0000);

  // R3
  blank_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (hblank || vblank) |-> ##2 !blank_n);

  // R3
  blank_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(blank_n) |-> $past(line_start, 2));

  // R1
  legal_colour_chk: assert property (@(posedge clk) disable iff (rst)
    blank_n |-> (rgb == 16'hFFFF || rgb == 16'h0000 || rgb == 16'h001F));

  // R8
  vblank_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (line_start && vblank) |-> ##2 !blank_n);

  generate
    if (BORDER > 0) begin : g_edge
      // R5
      first_pixel_blue_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(blank_n) |-> rgb == 16'h001F);
    end
  endgenerate
endmodule

bind bar_pattern_gen bpg_checker #(.BORDER(BORDER)) i_chk (
  .clk(clk), .rst(rst), .line_start(line_start), .hblank(hblank),
  .vblank(vblank), .red(red), .green(green), .blue(blue), .blank_n(blank_n)
);

// File: tb/test_bar_pattern_gen.sv
module test_bar_pattern_gen;
  localparam int W  = 144;
  localparam int H  = 22;
  localparam int B  = 4;
  localparam int HB = 16;
  localparam int BAND_H = (H - 2 * B) / 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_start = 1'b0;
  logic frame_start = 1'b0;
  logic hblank = 1'b1;
  logic vblank = 1'b1;
  logic [4:0] red;
  logic [5:0] green;
  logic [4:0] blue;
  logic blank_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        q_bn[$];
  logic [15:0] q_rgb[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  bar_pattern_gen #(.WIDTH(W), .HEIGHT(H), .BORDER(B)) i_bar_pattern_gen (
    .clk(clk), .rst(rst), .line_start(line_start), .frame_start(frame_start),
    .hblank(hblank), .vblank(vblank),
    .red(red), .green(green), .blue(blue), .blank_n(blank_n)
  );

  // Expected pixel from R1, R5, R6.
  function automatic logic [15:0] exp_pix(int x, int y);
    int band;
    int px;
    if (x < B || x >= W - B || y < B || y >= H - B) return 16'h001F;
    band = (y - B) / BAND_H;
    if (band > 6) band = 6;
    px = x - B;
    return ((px >> (6 - band)) & 1) ? 16'hFFFF : 16'h0000;
  endfunction

  task automatic tick(logic ls, logic fs, logic hb, logic vb,
                      logic e_bn, logic [15:0] e_rgb, string tag);
    @(posedge clk);
    #1;
    line_start  = ls;
    frame_start = fs;
    hblank      = hb;
    vblank      = vb;
    q_bn.push_back(e_bn);
    q_rgb.push_back(e_rgb);
    q_tag.push_back(tag);
  endtask

  // R4 R6 R7: visible line y, pixels x = 0..W-1
  task automatic vis_line(int y);
    for (int k = 0; k < W; k++) begin
      logic [15:0] e;
      e = exp_pix(k, y);
      tick(k == 0, 1'b0, 1'b0, 1'b0, 1'b1, e,
           (e == 16'h001F) ? "R5" : "R6 R4 R7");
    end
    for (int k = 0; k < HB; k++) tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, "R3");
  endtask

  // Vertical blanking line; optional frame pulse and stray line pulse (R8)
  task automatic vb_line(bit fs, bit stray);
    for (int k = 0; k < W + HB; k++)
      tick(stray && k == 0, fs && k == 3, k >= W, 1'b1, 1'b0, 16'h0,
           stray ? "R8" : "R3");
  endtask

  task automatic frame(bit stray);
    vb_line(1'b1, 1'b0);
    vb_line(1'b0, stray);
    for (int y = 0; y < H; y++) vis_line(y);
    vb_line(1'b0, 1'b0);
  endtask

  // Monitor / scoreboard: item for input cycle P appears after edge P+1.
  always @(negedge clk) begin
    if (!rst && q_bn.size() >= 3) begin
      logic        e_bn;
      logic [15:0] e_rgb;
      string       tag;
      e_bn  = q_bn.pop_front();
      e_rgb = q_rgb.pop_front();
      tag   = q_tag.pop_front();
      checks++;
      if (blank_n !== e_bn || {red, green, blue} !== e_rgb) begin
        errors++;
        $display("FAIL %s: got blank_n=%b rgb=%h, expected blank_n=%b rgb=%h",
                 tag, blank_n, {red, green, blue}, e_bn, e_rgb);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 reset state
    checks++;
    if (blank_n !== 1'b0 || {red, green, blue} !== 16'h0) begin
      errors++;
      $display("FAIL R2: got blank_n=%b rgb=%h, expected blank_n=0 rgb=0000",
               blank_n, {red, green, blue});
    end
    @(posedge clk);
    #1 rst = 1'b0;
    frame(1'b0);
    frame(1'b1);
    for (int k = 0; k < 4; k++) tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0, "R3");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected run to end");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule